// File: doc/BRIEF.md
# Three-Channel Interval Timer Host Interface

This block is the processor-facing register front end of a three-channel interval timer. It watches a 2-bit port address, active-low read and write strobes and an 8-bit data bus. Port 3 is a shared configuration port, and ports 0, 1 and 2 reach one counter channel each. A configuration byte names its own target channel in its top two bits and sets that channel's byte-access format, operating mode and BCD flag.

After configuration, software moves the 16-bit count one byte at a time through the channel's own port. It sends the low byte only, the high byte only, or the low byte and then the high byte. Each channel gives its counter core the decoded mode, the BCD flag, the assembled count and a one-cycle commit pulse. On reads it returns bytes of the count that the core reports, in the byte order set for that channel. The counter cores are outside this block.

Top module: `tmr_host_if`

## Requirements
- R1: After reset every channel is unconfigured: count 0, mode 0, BCD 0, no commit pulse, reads of ports 0 to 2 return 0, and count writes to a channel that has not been configured are ignored.
- R2: Ports 0, 1 and 2 address channels 0, 1 and 2 and port 3 is the configuration port. A write acts once per low period of the write strobe, in the clock edge where the strobe is first sampled low, however long the strobe stays low.
- R3: A configuration byte goes to the channel named by bits 7:6 (00, 01, 10). The value 11 changes no channel.
- R4: Configuration bits 3:1 give the mode and bit 0 the BCD flag (1 = BCD). Mode codes 110 and 111 are presented as modes 2 and 3, and codes 0 to 5 pass unchanged.
- R5: With format 01 in bits 5:4 (low byte only), one data byte commits the count {8'h00, byte}.
- R6: With format 10 (high byte only), one data byte commits the count {byte, 8'h00}.
- R7: With format 11, the first byte is held as the low half and the second byte commits {second, first}. No commit happens after the first byte. Each configuration write to the channel restarts the sequence at the low byte.
- R8: A commit raises that channel's load output for exactly one cycle, in the cycle after the accepting clock edge. The count output changes only in that cycle.
- R9: While the read strobe is low, the data output shows the core count byte picked by the channel's format: low byte for 01, high byte for 10, and low then high on successive reads for 11. That choice advances when the read strobe rises, and a configuration write to the channel restarts it at the low byte. Reads of port 3 return 0.
- R10: A configuration byte with format 00 in bits 5:4 leaves that channel's format, mode and BCD flag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Port address (3 = configuration, 0 to 2 = channels) |
| wrN | input | 1 | Active-low write strobe |
| rdN | input | 1 | Active-low read strobe |
| dIn | input | 8 | Write data byte |
| rdData | output | 8 | Read data byte |
| chCur | input | 48 | Current count of each counter core, channel 0 in the low 16 bits |
| chMode | output | 9 | Decoded mode per channel, 3 bits each |
| chBcd | output | 3 | BCD flag per channel |
| chLoad | output | 3 | One-cycle commit pulse per channel |
| chCount | output | 48 | Committed count per channel, 16 bits each |

## Verification
The bound checker watches cause and effect on every cycle. A commit pulse must follow a write strobe to that channel's port, and at most one channel may commit at a time. Counts and modes may not move without a commit or a configuration write, decoded modes never leave 0 to 5, and port 3 always reads as zero. The byte values themselves only show up in the bench's scenarios. These cover the assembled counts in each format, the low/high read alternation and its restart, ignored selector and format codes, writes before configuration, and a stretched write strobe.

// File: rtl/tmr_host_pkg.sv
package tmr_host_pkg;

  typedef enum logic [1:0] {
    FMT_NONE = 2'b00,
    FMT_LO   = 2'b01,
    FMT_HI   = 2'b10,
    FMT_BOTH = 2'b11
  } acc_fmt_e;

  // strobes from the bus decoder to every channel datapath
  typedef struct packed {
    logic       cwWr;   // configuration byte accepted this cycle
    logic       cntWr;  // count byte accepted this cycle
    logic       rdEnd;  // read strobe released this cycle
    logic [1:0] port;   // address sampled with the strobe
  } bus_stb_t;

  localparam logic [1:0] CFG_PORT = 2'd3;

  // fold the two spare mode codes onto modes 2 and 3
  function automatic logic [2:0] fold_mode(input logic [2:0] raw);
    return (raw[2] && raw[1]) ? {1'b0, raw[1:0]} : raw;
  endfunction

endpackage

// File: rtl/tmr_host_ctrl.sv
module tmr_host_ctrl
  import tmr_host_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] addr,
  input  logic       wrN,
  input  logic       rdN,
  output bus_stb_t   stb
);

  logic wrNQ;
  logic rdNQ;
  logic wrFire;
  logic rdRise;
  logic isCfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrNQ <= 1'b1;
      rdNQ <= 1'b1;
    end else begin
      wrNQ <= wrN;
      rdNQ <= rdN;
    end
  end

  // one action per strobe low period
  assign wrFire = wrNQ & ~wrN;
  assign rdRise = ~rdNQ & rdN;
  assign isCfg  = (addr == CFG_PORT);

  always_comb begin
    stb.cwWr  = wrFire & isCfg;
    stb.cntWr = wrFire & ~isCfg;
    stb.rdEnd = rdRise & ~isCfg;
    stb.port  = addr;
  end

endmodule

// File: rtl/tmr_host_chan.sv
module tmr_host_chan
  import tmr_host_pkg::*;
#(
  parameter int IDX   = 0,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_stb_t          stb,
  input  logic [7:0]        dIn,
  input  logic [CNT_W-1:0]  cur,
  output logic [2:0]        mode,
  output logic              bcd,
  output logic              load,
  output logic [CNT_W-1:0]  count,
  output logic [7:0]        rdByte
);

  localparam int          BYTE_W = CNT_W / 2;
  localparam logic [1:0]  MY_ID  = 2'(IDX);

  acc_fmt_e          fmt;
  logic              wrHi;
  logic              rdHi;
  logic [BYTE_W-1:0] loHold;
  logic              cwHit;
  logic              cntHit;
  logic              rdHit;

  assign cwHit  = stb.cwWr && (dIn[7:6] == MY_ID) && (dIn[5:4] != FMT_NONE);
  assign cntHit = stb.cntWr && (stb.port == MY_ID);
  assign rdHit  = stb.rdEnd && (stb.port == MY_ID);

  // configuration fields and byte-order state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt  <= FMT_NONE;
      mode <= 3'd0;
      bcd  <= 1'b0;
      wrHi <= 1'b0;
      rdHi <= 1'b0;
    end else if (cwHit) begin
      fmt  <= acc_fmt_e'(dIn[5:4]);
      mode <= fold_mode(dIn[3:1]);
      bcd  <= dIn[0];
      wrHi <= 1'b0;
      rdHi <= 1'b0;
    end else begin
      if (cntHit && fmt == FMT_BOTH) wrHi <= ~wrHi;
      if (rdHit && fmt == FMT_BOTH)  rdHi <= ~rdHi;
    end
  end

  // count assembly and commit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loHold <= '0;
      count  <= '0;
      load   <= 1'b0;
    end else begin
      load <= 1'b0;
      if (cntHit) begin
        unique case (fmt)
          FMT_LO: begin
            count <= {{BYTE_W{1'b0}}, dIn};
            load  <= 1'b1;
          end
          FMT_HI: begin
            count <= {dIn, {BYTE_W{1'b0}}};
            load  <= 1'b1;
          end
          FMT_BOTH: begin
            if (!wrHi) begin
              loHold <= dIn;
            end else begin
              count <= {dIn, loHold};
              load  <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // read byte selection
  always_comb begin
    unique case (fmt)
      FMT_LO:   rdByte = cur[BYTE_W-1:0];
      FMT_HI:   rdByte = cur[CNT_W-1:BYTE_W];
      FMT_BOTH: rdByte = rdHi ? cur[CNT_W-1:BYTE_W] : cur[BYTE_W-1:0];
      default:  rdByte = 8'h00;
    endcase
  end

endmodule

// File: rtl/tmr_host_if.sv
module tmr_host_if
  import tmr_host_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              addr,
  input  logic                    wrN,
  input  logic                    rdN,
  input  logic [7:0]              dIn,
  output logic [7:0]              rdData,
  input  logic [NUM_CH*CNT_W-1:0] chCur,
  output logic [NUM_CH*3-1:0]     chMode,
  output logic [NUM_CH-1:0]       chBcd,
  output logic [NUM_CH-1:0]       chLoad,
  output logic [NUM_CH*CNT_W-1:0] chCount
);

  bus_stb_t   stb;
  logic [7:0] rdArr [NUM_CH];

  tmr_host_ctrl u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (addr),
    .wrN   (wrN),
    .rdN   (rdN),
    .stb   (stb)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    tmr_host_chan #(
      .IDX   (c),
      .CNT_W (CNT_W)
    ) u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .stb    (stb),
      .dIn    (dIn),
      .cur    (chCur[c*CNT_W +: CNT_W]),
      .mode   (chMode[c*3 +: 3]),
      .bcd    (chBcd[c]),
      .load   (chLoad[c]),
      .count  (chCount[c*CNT_W +: CNT_W]),
      .rdByte (rdArr[c])
    );
  end

  always_comb begin
    rdData = 8'h00;
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr == 2'(c)) rdData = rdArr[c];
    end
  end

endmodule

// File: rtl/tmr_host_if_chk.sv
module tmr_host_if_chk #(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [1:0]              addr,
  input logic                    wrN,
  input logic                    rdN,
  input logic [7:0]              rdData,
  input logic [NUM_CH*3-1:0]     chMode,
  input logic [NUM_CH-1:0]       chLoad,
  input logic [NUM_CH*CNT_W-1:0] chCount
);

  AST_ONE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chLoad)); // R2

  AST_CFG_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdN && addr == 2'd3) |-> (rdData == 8'h00)); // R9

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    AST_COMMIT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      chLoad[c] |-> ($past(!wrN) && $past(addr) == 2'(c))); // R8

    AST_COUNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !chLoad[c] |-> $stable(chCount[c*CNT_W +: CNT_W])); // R8

    AST_MODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      chMode[c*3 +: 3] <= 3'd5); // R4

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wrN) || $past(addr) != 2'd3) |-> $stable(chMode[c*3 +: 3])); // R3
  end

endmodule

bind tmr_host_if tmr_host_if_chk #(
  .NUM_CH (NUM_CH),
  .CNT_W  (CNT_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .addr    (addr),
  .wrN     (wrN),
  .rdN     (rdN),
  .rdData  (rdData),
  .chMode  (chMode),
  .chLoad  (chLoad),
  .chCount (chCount)
);

// File: tb/test_tmr_host_if.sv
module test_tmr_host_if;

  localparam int NUM_CH = 3;
  localparam int CNT_W  = 16;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic [1:0]              addr = 2'd0;
  logic                    wrN = 1'b1;
  logic                    rdN = 1'b1;
  logic [7:0]              dIn = 8'h00;
  logic [7:0]              rdData;
  logic [NUM_CH*CNT_W-1:0] chCur;
  logic [NUM_CH*3-1:0]     chMode;
  logic [NUM_CH-1:0]       chBcd;
  logic [NUM_CH-1:0]       chLoad;
  logic [NUM_CH*CNT_W-1:0] chCount;

  int nRun  = 0;
  int nFail = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  // counter core stub: a frozen core reports its committed count
  assign chCur = chCount;

  tmr_host_if #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) i_tmr_host_if (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wrN(wrN), .rdN(rdN),
    .dIn(dIn), .rdData(rdData), .chCur(chCur), .chMode(chMode),
    .chBcd(chBcd), .chLoad(chLoad), .chCount(chCount)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic [1:0]  port;
    logic [15:0] val;
    logic [3:0]  req;
  } vec_t;

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_CNT = 2'd2, OP_CFG = 2'd3;
  localparam int NVEC = 42;

  localparam vec_t VEC [NVEC] = '{
    '{OP_WR,  2'd3, 16'h0034, 4'd4},  // ch0 both, mode 2
    '{OP_CFG, 2'd0, 16'h0004, 4'd4},  // R4
    '{OP_WR,  2'd0, 16'h009C, 4'd7},
    '{OP_CNT, 2'd0, 16'h0000, 4'd7},  // R7 no commit after first byte
    '{OP_WR,  2'd0, 16'h002E, 4'd7},
    '{OP_CNT, 2'd0, 16'h2E9C, 4'd7},  // R7
    '{OP_RD,  2'd0, 16'h009C, 4'd9},  // R9 low, high, low
    '{OP_RD,  2'd0, 16'h002E, 4'd9},
    '{OP_RD,  2'd0, 16'h009C, 4'd9},
    '{OP_WR,  2'd3, 16'h0054, 4'd5},  // ch1 low only, mode 2
    '{OP_WR,  2'd1, 16'h0012, 4'd5},
    '{OP_CNT, 2'd1, 16'h0012, 4'd5},  // R5
    '{OP_CFG, 2'd1, 16'h0004, 4'd4},
    '{OP_WR,  2'd3, 16'h00A7, 4'd6},  // ch2 high only, mode 3, BCD
    '{OP_CFG, 2'd2, 16'h0007, 4'd4},
    '{OP_WR,  2'd2, 16'h0005, 4'd6},
    '{OP_CNT, 2'd2, 16'h0500, 4'd6},  // R6
    '{OP_RD,  2'd2, 16'h0005, 4'd9},
    '{OP_RD,  2'd2, 16'h0005, 4'd9},
    '{OP_WR,  2'd3, 16'h001D, 4'd4},  // mode code 110, BCD
    '{OP_CFG, 2'd0, 16'h0005, 4'd4},
    '{OP_WR,  2'd3, 16'h001E, 4'd4},  // mode code 111
    '{OP_CFG, 2'd0, 16'h0006, 4'd4},
    '{OP_WR,  2'd3, 16'h00F6, 4'd3},  // selector 11
    '{OP_CFG, 2'd0, 16'h0006, 4'd3},  // R3
    '{OP_CFG, 2'd1, 16'h0004, 4'd3},
    '{OP_CFG, 2'd2, 16'h0007, 4'd3},
    '{OP_WR,  2'd3, 16'h000A, 4'd10}, // format 00 to ch0
    '{OP_CFG, 2'd0, 16'h0006, 4'd10}, // R10
    '{OP_WR,  2'd0, 16'h0077, 4'd10},
    '{OP_CNT, 2'd0, 16'h0077, 4'd10}, // still low-only
    '{OP_RD,  2'd3, 16'h0000, 4'd9},
    '{OP_WR,  2'd3, 16'h0030, 4'd7},  // ch0 both
    '{OP_WR,  2'd0, 16'h00AA, 4'd7},
    '{OP_WR,  2'd3, 16'h0030, 4'd7},  // restart sequence
    '{OP_CNT, 2'd0, 16'h0077, 4'd7},
    '{OP_WR,  2'd0, 16'h0011, 4'd7},
    '{OP_WR,  2'd0, 16'h0022, 4'd7},
    '{OP_CNT, 2'd0, 16'h2211, 4'd7},
    '{OP_RD,  2'd0, 16'h0011, 4'd9},
    '{OP_WR,  2'd3, 16'h0030, 4'd9},  // restart read order
    '{OP_RD,  2'd0, 16'h0011, 4'd9}
  };

  task automatic check(input int req, input string what, input logic [15:0] act, input logic [15:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic busWr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; dIn = d; wrN = 1'b0;
    @(negedge clk); wrN = 1'b1;
    @(negedge clk);
  endtask

  task automatic busRd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rdN = 1'b0;
    @(negedge clk); d = rdData; rdN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    logic [7:0] rb;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(1, "reset counts", 16'(chCount[15:0] | chCount[31:16] | chCount[47:32]), 16'h0000);
    check(1, "reset modes/bcd/load", 16'({chMode, chBcd, chLoad}), 16'h0000);
    busRd(2'd1, rb);
    check(1, "reset read ch1", 16'(rb), 16'h0000);
    busWr(2'd0, 8'h55);
    check(1, "unconfigured write ignored", chCount[15:0], 16'h0000);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      v = VEC[i];
      case (v.op)
        OP_WR:  busWr(v.port, v.val[7:0]);
        OP_RD: begin
          busRd(v.port, rb);
          check(int'(v.req), $sformatf("read port %0d vec %0d", v.port, i), 16'(rb), v.val);
        end
        OP_CNT: check(int'(v.req), $sformatf("count ch%0d vec %0d", v.port, i),
                      chCount[v.port*16 +: 16], v.val);
        default: check(int'(v.req), $sformatf("mode/bcd ch%0d vec %0d", v.port, i),
                       16'({chMode[v.port*3 +: 3], chBcd[v.port]}), v.val);
      endcase
    end

    // R8 commit pulse width and timing
    busWr(2'd3, 8'h90);
    @(negedge clk); addr = 2'd2; dIn = 8'h3C; wrN = 1'b0;
    @(negedge clk);
    check(8, "load pulse high", 16'(chLoad), 16'h0004);
    check(8, "count with pulse", chCount[47:32], 16'h003C);
    wrN = 1'b1;
    @(negedge clk);
    check(8, "load pulse ends", 16'(chLoad), 16'h0000);

    // R2 stretched write strobe takes one byte only
    busWr(2'd3, 8'h70);
    @(negedge clk); addr = 2'd1; dIn = 8'h01; wrN = 1'b0;
    repeat (4) @(negedge clk);
    wrN = 1'b1;
    @(negedge clk);
    check(2, "no commit after long first byte", chCount[31:16], 16'h0012);
    busWr(2'd1, 8'h02);
    check(2, "long strobe single action", chCount[31:16], 16'h0201);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule